// File: doc/BRIEF.md
# Phase-Stepped PWM Motor Driver

This block produces a pulse-width modulated enable for the H-bridge of a brushed DC motor. The duty word is set by a phase comparison, not written by software. An external phase detector compares the motor's once-per-revolution pulse with a reference clock. Each time it has a new verdict, it pulses a strobe and reports whether the motor was ahead or behind. The block then moves its duty word by a single count: down when the motor is ahead, up when it is behind. The duty word therefore acts as a bang-bang integrator of the lead/lag decisions.

A coarse duty can be preset through a load strobe, so that the motor is already close to the target speed before fine stepping begins. The PWM is a free-running counter compared against the duty word. A duty change takes effect only when the counter wraps, so no period is ever cut or stretched mid-way. The enable input gates both the output and the stepping. Dead-time generation and any proportional or derivative control sit outside this block.

Top module: `pwm_phase_stepper`

## Requirements
- R1: During and immediately after reset the duty word `duty_o` is 0 and `pwm_o` is low.
- R2: When `step_stb` is high, `en` is high, `load_stb` is low and `motor_lead` is 0 (motor lagging), `duty_o` is one count higher in the next cycle.
- R3: When `step_stb` is high, `en` is high, `load_stb` is low and `motor_lead` is 1 (motor leading), `duty_o` is one count lower in the next cycle.
- R4: The duty word saturates: a lag step at 2^DUTY_W-1 and a lead step at 0 leave it unchanged, and it never wraps.
- R5: A high `load_stb` puts `load_val` into `duty_o` in the next cycle, whatever the state of `en` and even when a step strobe arrives in the same cycle.
- R6: While `en` is low, `pwm_o` is low and step strobes leave `duty_o` unchanged.
- R7: A DUTY_W-bit counter (DUTY_W defaults to 16) counts 0 to 2^DUTY_W-1, one step per clock, and wraps to 0. While `en` is high, `pwm_o` is high exactly when the counter is below the applied duty.
- R8: The applied duty is the value `duty_o` has during the last cycle of a period (counter at its maximum). That value governs the whole of the next period, so duty changes made mid-period do not alter the current pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Drive enable; gates the output and the stepping |
| step_stb | input | 1 | One-cycle pulse: a new phase verdict is ready |
| motor_lead | input | 1 | Verdict: 1 = motor ahead of the reference, 0 = behind |
| load_stb | input | 1 | One-cycle pulse: load the coarse duty |
| load_val | input | DUTY_W | Coarse duty to load |
| pwm_o | output | 1 | PWM enable to the H-bridge |
| duty_o | output | DUTY_W | Current duty word (integrator state) |

## Verification
Random step sequences with a mixed lead/lag balance show that the integrator follows the net count of verdicts. Long one-sided runs started from loads near the top and near zero push the duty word against both rails, which separates saturation from wrap-around. Loads that coincide with steps show that the load wins, and stretches with enable low, with strobes still active, show that the output is held low and the steps are discarded. A step placed in the last cycle of a period, compared with one placed mid-period, shows whether the pulse width changes only at the period boundary.

// File: rtl/pwmstep_pkg.sv
package pwmstep_pkg;

   // Action applied to the duty integrator in a given cycle
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_UP   = 2'd1,
      ACT_DOWN = 2'd2,
      ACT_LOAD = 2'd3
   } duty_act_e;

endpackage

// File: rtl/pwmstep_integrator.sv
module pwmstep_integrator
   import pwmstep_pkg::*;
#(
   parameter int DUTY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              step_stb,
   input  logic              motor_lead,
   input  logic              load_stb,
   input  logic [DUTY_W-1:0] load_val,
   output logic [DUTY_W-1:0] duty_o
);

   localparam logic [DUTY_W-1:0] DUTY_MAX = {DUTY_W{1'b1}};
   localparam logic [DUTY_W-1:0] DUTY_MIN = '0;

   generate
      if (DUTY_W < 2) begin : g_bad_width
         $error("pwmstep_integrator: DUTY_W must be at least 2");
      end
   endgenerate

   duty_act_e         act;
   logic [DUTY_W-1:0] duty_q;
   logic [DUTY_W-1:0] duty_d;

   // Load has priority; steps only count while enabled
   always_comb begin
      if (load_stb)
         act = ACT_LOAD;
      else if (step_stb && en)
         act = motor_lead ? ACT_DOWN : ACT_UP;
      else
         act = ACT_HOLD;
   end

   always_comb begin
      unique case (act)
         ACT_LOAD: duty_d = load_val;
         ACT_UP:   duty_d = (duty_q == DUTY_MAX) ? duty_q : duty_q + 1'b1;
         ACT_DOWN: duty_d = (duty_q == DUTY_MIN) ? duty_q : duty_q - 1'b1;
         default:  duty_d = duty_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         duty_q <= '0;
      else
         duty_q <= duty_d;
   end

   assign duty_o = duty_q;

   // R4
   duty_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_stb) |->
         ({1'b0, duty_q} == {1'b0, $past(duty_q)}) ||
         ({1'b0, duty_q} == {1'b0, $past(duty_q)} + 1'b1) ||
         ({1'b0, duty_q} + 1'b1 == {1'b0, $past(duty_q)}));

   // R5
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> (duty_q == $past(load_val)));

   // R6
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load_stb) |=> $stable(duty_q));

endmodule

// File: rtl/pwmstep_period_counter.sv
module pwmstep_period_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o
);

   localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pwmstep_period_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == CNT_LAST);

   // R7
   cnt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/pwmstep_compare.sv
module pwmstep_compare #(
   parameter int DUTY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DUTY_W-1:0] cnt_i,
   input  logic              last_i,
   input  logic [DUTY_W-1:0] duty_i,
   output logic              pwm_o
);

   logic [DUTY_W-1:0] applied_q;

   // Shadow register: take the new duty only as a period ends
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         applied_q <= '0;
      else if (last_i)
         applied_q <= duty_i;
   end

   assign pwm_o = en && (cnt_i < applied_q);

   // R8
   applied_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_i != '0) |-> $stable(applied_q));

   // R6
   pwm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_o |-> en);

endmodule

// File: rtl/pwm_phase_stepper.sv
module pwm_phase_stepper #(
   parameter int DUTY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              step_stb,
   input  logic              motor_lead,
   input  logic              load_stb,
   input  logic [DUTY_W-1:0] load_val,
   output logic              pwm_o,
   output logic [DUTY_W-1:0] duty_o
);

   logic [DUTY_W-1:0] cnt;
   logic              cnt_last;
   logic [DUTY_W-1:0] duty;

   pwmstep_integrator #(.DUTY_W(DUTY_W)) u_integ (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .step_stb   (step_stb),
      .motor_lead (motor_lead),
      .load_stb   (load_stb),
      .load_val   (load_val),
      .duty_o     (duty)
   );

   pwmstep_period_counter #(.CNT_W(DUTY_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_o  (cnt),
      .last_o (cnt_last)
   );

   pwmstep_compare #(.DUTY_W(DUTY_W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .cnt_i  (cnt),
      .last_i (cnt_last),
      .duty_i (duty),
      .pwm_o  (pwm_o)
   );

   assign duty_o = duty;

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (duty_o == '0) && !pwm_o);

endmodule

// File: tb/pwm_phase_stepper_test.sv
module pwm_phase_stepper_test;

   localparam int W    = 6;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic         step_stb = 1'b0;
   logic         motor_lead = 1'b0;
   logic         load_stb = 1'b0;
   logic [W-1:0] load_val = '0;
   logic         pwm_o;
   logic [W-1:0] duty_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // Bench model state
   int m_cnt = 0, m_duty = 0, m_applied = 0;
   string m_tag = "R1";

   always #2.5 clk = ~clk;

   pwm_phase_stepper #(.DUTY_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .step_stb(step_stb),
      .motor_lead(motor_lead), .load_stb(load_stb), .load_val(load_val),
      .pwm_o(pwm_o), .duty_o(duty_o)
   );

   function automatic int next_duty(int d, bit ld, int lv, bit e, bit s, bit lead);
      if (ld) return lv;
      if (!(e && s)) return d;
      if (lead) return (d == 0) ? 0 : d - 1;
      return (d == MAXV) ? MAXV : d + 1;
   endfunction

   function automatic string duty_tag(int d, bit ld, bit e, bit s, bit lead);
      if (ld) return "R5";
      if (s && !e) return "R6";
      if (s && lead && d == 0) return "R4";
      if (s && !lead && d == MAXV) return "R4";
      if (s && lead) return "R3";
      if (s) return "R2";
      return "R2";
   endfunction

   // Model advances on the same edge as the design; inputs change at negedge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_cnt = 0; m_duty = 0; m_applied = 0; m_tag = "R1";
      end else begin
         if (m_cnt == MAXV) m_applied = m_duty;
         m_cnt = (m_cnt + 1) % (MAXV + 1);
         m_tag = duty_tag(m_duty, load_stb, en, step_stb, motor_lead);
         m_duty = next_duty(m_duty, load_stb, int'(load_val), en, step_stb, motor_lead);
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // Compare every cycle at the falling edge
   task automatic cycle_check();
      @(negedge clk);
      check(m_tag, int'(duty_o), m_duty);
      if (!en) check("R6", int'(pwm_o), 0);
      else     check("R7", int'(pwm_o), (m_cnt < m_applied) ? 1 : 0);
   endtask

   task automatic drive(bit e, bit s, bit lead, bit ld, int lv);
      en = e; step_stb = s; motor_lead = lead; load_stb = ld; load_val = W'(lv);
      cycle_check();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(en, 1'b0, 1'b0, 1'b0, 0);
   endtask

   // Wait until the model counter shows the given value (at negedge)
   task automatic wait_cnt(int c);
      while (m_cnt != c) idle(1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      int seed;
      seed = $urandom(32'd20240611);
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", int'(duty_o), 0);
      check("R1", int'(pwm_o), 0);
      rst_n = 1'b1;
      cycle_check();
      check("R1", int'(duty_o), 0);

      // R5 load while disabled, R6 steps ignored and output low
      drive(1'b0, 1'b0, 1'b0, 1'b1, 40);
      for (int i = 0; i < 20; i++) drive(1'b0, 1'b1, i[0], 1'b0, 0);
      check("R6", int'(duty_o), 40);

      // R2 lag steps up to and against the top rail (R4)
      drive(1'b1, 1'b0, 1'b0, 1'b1, MAXV - 3);
      for (int i = 0; i < 8; i++) drive(1'b1, 1'b1, 1'b0, 1'b0, 0);
      check("R4", int'(duty_o), MAXV);

      // R3 lead steps down to and against zero (R4)
      drive(1'b1, 1'b0, 1'b0, 1'b1, 3);
      for (int i = 0; i < 8; i++) drive(1'b1, 1'b1, 1'b1, 1'b0, 0);
      check("R4", int'(duty_o), 0);

      // R5 load coinciding with a step
      drive(1'b1, 1'b1, 1'b0, 1'b1, 20);
      check("R5", int'(duty_o), 20);
      drive(1'b1, 1'b1, 1'b1, 1'b1, 50);
      check("R5", int'(duty_o), 50);

      // R8: step mid-period does not change the running pulse
      drive(1'b1, 1'b0, 1'b0, 1'b1, 30);
      wait_cnt(0);
      idle(10);
      drive(1'b1, 1'b1, 1'b0, 1'b0, 0);
      idle(40);
      // step in the last cycle of the period is taken for the next one
      wait_cnt(MAXV - 1);
      drive(1'b1, 1'b1, 1'b0, 1'b0, 0);
      idle(2 * (MAXV + 1));

      // R7/R2/R3 constrained random: mostly steps, occasional loads and disables
      for (int i = 0; i < 2000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         drive((r % 17) != 0, $urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1,
               r < 3, $urandom_range(0, MAXV));
      end

      // R6 output low across a full period with steps pending
      for (int i = 0; i <= MAXV; i++) drive(1'b0, 1'b1, 1'b0, 1'b0, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule